// File: doc/BRIEF.md
# Digital Microphone Capture Controller

This block captures up to three stereo pairs of pulse-density microphones. It produces the microphone bit clock by dividing its own clock, using a 3-bit ratio code. It samples one line per pair: the left channel on the rising microphone edge and the right channel on the falling edge. Each pair has a polarity flip. The decimation stage is a stub: it counts the ones a channel sees over a frame of `FRAME_LEN` microphone periods and returns the count as that frame's 24-bit sample.

At the end of each frame the samples of the enabled pairs are written into a FIFO in a fixed order. The data are formatted as left- or right-justified 32-bit words. A host on a simple 32-bit register bus drains the FIFO, or a DMA engine drains it when the fill level reaches a threshold scaled by the active channel count. Interrupt enables and the DMA enable each have their own write-one-to-set and write-one-to-clear registers.

Top module: `pdm_capture_ctrl`

## Requirements
- R1: Register offsets are fixed: 0x24 raw status, 0x28 masked status, 0x2C and 0x30 interrupt enable set and clear, 0x38 and 0x3C DMA enable set and clear, 0x44 control, 0x48 data, 0x4C FIFO control. After reset every register reads zero. Control bits 9:0 read back as written.
- R2: Control bits 9:7 hold a ratio code. The microphone clock period in functional clock cycles is 8, 5, 10, 8, 16, 5, 5 for codes 0 to 6, and 8 for code 7. A new code takes effect only when the running period completes.
- R3: `mic_clk` is low from the cycle after the last effective pair is disabled, and it stays low while no pair is effective.
- R4: Control bits 2:0 are the pair enables, with bit 0 for pair 1. Pair 2 is effective only together with pair 1. Pair 3 is effective only together with pairs 1 and 2. With pair 1 off, nothing is captured and the clock does not run.
- R5: A channel's sample is the number of ones seen over one frame. The left channel counts on rising microphone edges and the right channel on falling edges. The line of a pair is `pdm_in[pair]`, and it is inverted when polarity bit 4+pair of control is set.
- R6: Control bit 3 selects the justification. A value of 0 places the 24-bit sample in word bits 31:8. A value of 1 places it in bits 23:0, with zero above.
- R7: Each frame writes 2, 4 or 6 words, in the order pair 1 left, pair 1 right, pair 2 left, pair 2 right, pair 3 left, pair 3 right, and covers only effective pairs.
- R8: A read of 0x48 returns the oldest word and removes it. A read of an empty FIFO returns zero and sets raw status bit 3.
- R9: Writing 1 to bit 0 of 0x38 enables DMA requests, and writing 1 to bit 0 of 0x3C disables them. Both offsets read the enable in bit 0.
- R10: `dma_req` is high exactly when DMA is enabled, pair 1 is effective and the fill level is at least max(threshold,1) times the channel count. The threshold is FIFO control bits 3:0.
- R11: Raw status bits are sticky. Bit 0 is set when the threshold is reached. Bit 1 is set when the FIFO is full. Bit 2 is set when a pop leaves the FIFO below the threshold. Bit 3 is set on an empty read. Offset 0x28 reads raw AND enable, and writing 1 there clears a bit. `irq` is the OR of the enabled raw bits.
- R12: Writing 1 to control bit 10 empties the FIFO and clears raw status. The bit always reads 0.
- R13: The FIFO holds `DEPTH` words. FIFO control bits 23:16 read the fill level. A word arriving while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; pops on the data offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| pdm_in | input | 3 | One pulse-density line per pair |
| mic_clk | output | 1 | Microphone bit clock |
| dma_req | output | 1 | DMA request level |
| irq | output | 1 | Interrupt request level |

## Verification
Several properties are checked on every cycle by the assertions:
- the divider counter stays inside its period and the ratio changes only at a period boundary;
- the clock is low while idle;
- the nesting of the latched frame enables holds, and each frame's word sequence completes before the next frame ends;
- the fill level never exceeds the depth or moves by more than one word per cycle;
- a DMA-clear write and a soft reset have the expected effect one or two cycles later.

Other behaviour is shown only by the bench scenarios, which compare drained words against an expected-word queue. These cover:
- the measured period for each ratio code;
- sample values under different polarity and justification settings;
- channel order and partial enable patterns;
- the threshold scaled by channel count;
- overflow at full depth;
- the interrupt set and clear sequence.

// File: rtl/pdmc_pkg.sv
package pdmc_pkg;
   localparam logic [7:0] OFF_RAW   = 8'h24;
   localparam logic [7:0] OFF_STAT  = 8'h28;
   localparam logic [7:0] OFF_IESET = 8'h2C;
   localparam logic [7:0] OFF_IECLR = 8'h30;
   localparam logic [7:0] OFF_DSET  = 8'h38;
   localparam logic [7:0] OFF_DCLR  = 8'h3C;
   localparam logic [7:0] OFF_CTRL  = 8'h44;
   localparam logic [7:0] OFF_DATA  = 8'h48;
   localparam logic [7:0] OFF_FIFO  = 8'h4C;

   // control word, MSB first: bit 10 down to bit 0
   typedef struct packed {
      logic       soft_rst;
      logic [2:0] div_code;
      logic [2:0] flip;
      logic       rjust;
      logic [2:0] pair_on;
   } ctrl_t;

   // period length in functional clock cycles for each ratio code
   function automatic logic [4:0] div_ratio(input logic [2:0] code);
      case (code)
         3'd0: div_ratio = 5'd8;
         3'd1: div_ratio = 5'd5;
         3'd2: div_ratio = 5'd10;
         3'd3: div_ratio = 5'd8;
         3'd4: div_ratio = 5'd16;
         3'd5: div_ratio = 5'd5;
         3'd6: div_ratio = 5'd5;
         default: div_ratio = 5'd8;
      endcase
   endfunction
endpackage

// File: rtl/pdmc_clkgen.sv
module pdmc_clkgen
   import pdmc_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] code,
   output logic       mic_clk,
   output logic       rise_evt,
   output logic       fall_evt,
   output logic       period_end
);
   if (CNT_W < 5) begin : g_bad_cnt
      $error("pdmc_clkgen: CNT_W must hold the largest ratio");
   end

   logic [CNT_W-1:0] cnt_q, ratio_q;
   logic [CNT_W-1:0] half;
   logic             mic_q;

   assign half       = ratio_q >> 1;
   assign rise_evt   = run && (cnt_q == '0);
   assign fall_evt   = run && (cnt_q == half);
   assign period_end = run && (cnt_q == ratio_q - 1'b1);
   assign mic_clk    = mic_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= CNT_W'(5'd8);
         mic_q   <= 1'b0;
      end else if (!run) begin
         cnt_q   <= '0;
         ratio_q <= CNT_W'(div_ratio(code));
         mic_q   <= 1'b0;
      end else begin
         if (period_end) begin
            cnt_q   <= '0;
            ratio_q <= CNT_W'(div_ratio(code));
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (rise_evt)      mic_q <= 1'b1;
         else if (fall_evt) mic_q <= 1'b0;
      end
   end

   // R2: counter never leaves the current period
   p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio_q);
   // R2: ratio only reloads at a period boundary while running
   p_ratio_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !period_end) |=> $stable(ratio_q));
   // R3: idle clock is low
   p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mic_clk);
endmodule

// File: rtl/pdmc_capture.sv
module pdmc_capture #(
   parameter int SAMPLE_W  = 24,
   parameter int WORD_W    = 32,
   parameter int FRAME_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [2:0]        pairs_en,
   input  logic [2:0]        pol,
   input  logic              rjust,
   input  logic [2:0]        pdm_in,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              period_end,
   output logic              push_vld,
   output logic [WORD_W-1:0] push_data
);
   localparam int NCH    = 6;
   localparam int PAD    = WORD_W - SAMPLE_W;
   localparam int FCNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

   if (SAMPLE_W >= WORD_W) begin : g_bad_w
      $error("pdmc_capture: sample must be narrower than word");
   end
   if (FRAME_LEN < 1) begin : g_bad_f
      $error("pdmc_capture: FRAME_LEN must be at least 1");
   end

   logic [NCH-1:0]      line_v, evt_v;
   logic [SAMPLE_W-1:0] acc_q  [NCH];
   logic [SAMPLE_W-1:0] snap_q [NCH];
   logic [FCNT_W-1:0]   fcnt_q;
   logic                frame_end;
   logic                seq_busy;
   logic [2:0]          seq_idx;
   logic [2:0]          seq_en;
   logic [SAMPLE_W-1:0] cur;

   // left channels count on rising edges, right ones on falling edges
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign line_v[c] = pdm_in[c/2] ^ pol[c/2];
      if (c % 2 == 0) begin : g_left
         assign evt_v[c] = rise_evt;
      end else begin : g_right
         assign evt_v[c] = fall_evt;
      end
   end

   assign frame_end = period_end && (fcnt_q == FCNT_W'(FRAME_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         for (int c = 0; c < NCH; c++) begin
            acc_q[c]  <= '0;
            snap_q[c] <= '0;
         end
      end else if (!run) begin
         fcnt_q <= '0;
         for (int c = 0; c < NCH; c++) acc_q[c] <= '0;
      end else begin
         if (period_end) fcnt_q <= frame_end ? '0 : fcnt_q + 1'b1;
         for (int c = 0; c < NCH; c++) begin
            if (frame_end) begin
               snap_q[c] <= acc_q[c];
               acc_q[c]  <= '0;
            end else if (evt_v[c] && line_v[c]) begin
               acc_q[c] <= acc_q[c] + 1'b1;
            end
         end
      end
   end

   // emit one word per cycle in fixed channel order after each frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_busy <= 1'b0;
         seq_idx  <= '0;
         seq_en   <= '0;
      end else if (frame_end) begin
         seq_busy <= 1'b1;
         seq_idx  <= '0;
         seq_en   <= pairs_en;
      end else if (seq_busy) begin
         if (seq_idx == 3'(NCH - 1)) seq_busy <= 1'b0;
         else                        seq_idx  <= seq_idx + 1'b1;
      end
   end

   assign cur       = snap_q[seq_idx];
   assign push_vld  = seq_busy && seq_en[seq_idx[2:1]];
   assign push_data = rjust ? WORD_W'(cur) : {cur, {PAD{1'b0}}};

   // R4: latched enables always form a nested group
   p_seq_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seq_busy |-> ((!seq_en[1] || seq_en[0]) && (!seq_en[2] || seq_en[1])));
   // R7: a frame's word sequence finishes before the next frame closes
   p_seq_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !seq_busy);
endmodule

// File: rtl/pdmc_fifo.sv
module pdmc_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int LW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("pdmc_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == LW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = empty ? '0 : mem[rp_q];
   assign level   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R13: the level is bounded by the depth
   p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   // R13: the level moves by at most one word per cycle
   p_level_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (level == $past(level) || level == $past(level) + 1'b1
                  || level + 1'b1 == $past(level)));
   // R8: a pop of an empty FIFO leaves it empty
   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> (level == '0));
endmodule

// File: rtl/pdm_capture_ctrl.sv
module pdm_capture_ctrl
   import pdmc_pkg::*;
#(
   parameter int DEPTH     = 128,
   parameter int FRAME_LEN = 4,
   parameter int SAMPLE_W  = 24
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [2:0]  pdm_in,
   output logic        mic_clk,
   output logic        dma_req,
   output logic        irq
);
   localparam int LW = $clog2(DEPTH + 1);
   localparam int CW = (LW > 7) ? LW : 7;

   if (LW > 8) begin : g_bad_lvl
      $error("pdm_capture_ctrl: level field is 8 bits wide");
   end

   ctrl_t         ctrl_q;
   logic [3:0]    thr_q, irq_en_q, raw_q, raw_set;
   logic          dma_en_q;
   logic [2:0]    en_eff;
   logic          any_on;
   logic [1:0]    npair;
   logic [CW-1:0] thr_words, level_cw;
   logic [LW-1:0] level;
   logic          full, empty, pop;
   logic          push_vld;
   logic [31:0]   push_data, fifo_rd;
   logic          rise_evt, fall_evt, period_end;
   logic          wr_ctrl, wr_stat;
   logic          unused_bits;

   assign unused_bits = ^{bus_wdata[31:11]};

   // nested group enable: higher pairs only with all lower ones
   assign en_eff[0] = ctrl_q.pair_on[0];
   assign en_eff[1] = ctrl_q.pair_on[1] & en_eff[0];
   assign en_eff[2] = ctrl_q.pair_on[2] & en_eff[1];
   assign any_on    = en_eff[0];
   assign npair     = 2'(en_eff[0]) + 2'(en_eff[1]) + 2'(en_eff[2]);
   assign thr_words = CW'((thr_q == 4'd0) ? 4'd1 : thr_q) * CW'({npair, 1'b0});
   assign level_cw  = CW'(level);

   assign wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
   assign wr_stat = bus_wr && (bus_addr == OFF_STAT);
   assign pop     = bus_rd && (bus_addr == OFF_DATA);

   pdmc_clkgen #(.CNT_W(5)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(any_on), .code(ctrl_q.div_code),
      .mic_clk(mic_clk), .rise_evt(rise_evt), .fall_evt(fall_evt),
      .period_end(period_end)
   );

   pdmc_capture #(.SAMPLE_W(SAMPLE_W), .WORD_W(32), .FRAME_LEN(FRAME_LEN)) u_cap (
      .clk(clk), .rst_n(rst_n), .run(any_on), .pairs_en(en_eff),
      .pol(ctrl_q.flip), .rjust(ctrl_q.rjust), .pdm_in(pdm_in),
      .rise_evt(rise_evt), .fall_evt(fall_evt), .period_end(period_end),
      .push_vld(push_vld), .push_data(push_data)
   );

   pdmc_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(ctrl_q.soft_rst), .push(push_vld),
      .wdata(push_data), .pop(pop), .rdata(fifo_rd), .level(level),
      .full(full), .empty(empty)
   );

   assign raw_set[0] = any_on && (level_cw >= thr_words);
   assign raw_set[1] = full;
   assign raw_set[2] = pop && !empty && (level_cw - 1'b1 < thr_words);
   assign raw_set[3] = pop && empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         thr_q    <= '0;
         irq_en_q <= '0;
         dma_en_q <= 1'b0;
         raw_q    <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[10:0]);
         else         ctrl_q.soft_rst <= 1'b0;
         if (bus_wr && bus_addr == OFF_FIFO)  thr_q <= bus_wdata[3:0];
         if (bus_wr && bus_addr == OFF_IESET) irq_en_q <= irq_en_q | bus_wdata[3:0];
         if (bus_wr && bus_addr == OFF_IECLR) irq_en_q <= irq_en_q & ~bus_wdata[3:0];
         if (bus_wr && bus_addr == OFF_DSET && bus_wdata[0]) dma_en_q <= 1'b1;
         if (bus_wr && bus_addr == OFF_DCLR && bus_wdata[0]) dma_en_q <= 1'b0;
         if (ctrl_q.soft_rst) raw_q <= '0;
         else raw_q <= (raw_q & ~(wr_stat ? bus_wdata[3:0] : 4'h0)) | raw_set;
      end
   end

   assign dma_req = dma_en_q && any_on && (level_cw >= thr_words);
   assign irq     = |(raw_q & irq_en_q);

   always_comb begin
      case (bus_addr)
         OFF_RAW:              bus_rdata = 32'(raw_q);
         OFF_STAT:             bus_rdata = 32'(raw_q & irq_en_q);
         OFF_IESET, OFF_IECLR: bus_rdata = 32'(irq_en_q);
         OFF_DSET, OFF_DCLR:   bus_rdata = 32'(dma_en_q);
         OFF_CTRL:             bus_rdata = 32'(ctrl_q) & 32'h3FF;
         OFF_DATA:             bus_rdata = fifo_rd;
         OFF_FIFO:             bus_rdata = 32'(thr_q) | (32'(level) << 16);
         default:              bus_rdata = '0;
      endcase
   end

   // R9: a clear write removes the request in the next cycle
   p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFF_DCLR && bus_wdata[0]) |=> !dma_req);
   // R12: soft reset empties the FIFO two edges after the write
   p_soft_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[10]) |=> ##1 (level == '0));
endmodule

// File: tb/sim_pdm_capture_ctrl.sv
module sim_pdm_capture_ctrl;
   localparam int FRAME = 4;
   localparam int DEPTH = 128;
   localparam logic [7:0] A_RAW = 8'h24, A_STAT = 8'h28, A_IESET = 8'h2C,
      A_IECLR = 8'h30, A_DSET = 8'h38, A_DCLR = 8'h3C, A_CTRL = 8'h44,
      A_DATA = 8'h48, A_FIFO = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  pdm_in = '0;
   logic        mic_clk, dma_req, irq;

   int total = 0, bad = 0, cyc = 0;
   logic [31:0] expq[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   pdm_capture_ctrl #(.DEPTH(DEPTH), .FRAME_LEN(FRAME)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pdm_in(pdm_in), .mic_clk(mic_clk), .dma_req(dma_req), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_rise(output int t);
      logic p;
      bit got;
      p = mic_clk; got = 1'b0;
      while (!got) begin
         @(negedge clk);
         if (mic_clk && !p) got = 1'b1;
         p = mic_clk;
      end
      t = cyc;
   endtask

   function automatic logic [31:0] exp_word(input int ch, input logic [2:0] pol,
                                            input logic rj, input logic [2:0] pdm);
      logic [23:0] s;
      s = (pdm[ch/2] ^ pol[ch/2]) ? 24'(FRAME) : 24'd0;
      return rj ? {8'd0, s} : {s, 8'd0};
   endfunction

   // monitor: pop the design's FIFO and compare against the queue
   task automatic drain(input string req);
      logic [31:0] v, e;
      while (expq.size() > 0) begin
         e = expq.pop_front();
         brd(A_DATA, v);
         chk(req, v, e);
      end
   endtask

   // driver: run a capture, then queue the expected words per frame
   task automatic cap_run(input logic [2:0] en, input logic [2:0] pol,
                          input logic rj, input logic [2:0] pdm);
      logic [31:0] ctl, v;
      int nch, frames;
      logic [2:0] eff;
      eff[0] = en[0]; eff[1] = en[1] & eff[0]; eff[2] = en[2] & eff[1];
      nch = 2 * (int'(eff[0]) + int'(eff[1]) + int'(eff[2]));
      bwr(A_CTRL, 32'h400);
      pdm_in = pdm;
      ctl = 32'(en) | (32'(rj) << 3) | (32'(pol) << 4) | (32'd1 << 7);
      bwr(A_CTRL, ctl);
      repeat (120) @(negedge clk);
      bwr(A_CTRL, ctl & ~32'h7);
      repeat (10) @(negedge clk);
      brd(A_FIFO, v);
      v = (v >> 16) & 32'hFF;
      chk("R7 words per frame", 32'((v > 0) && (v % nch == 0)), 32'd1);
      frames = int'(v) / nch;
      for (int f = 0; f < frames; f++)
         for (int c = 0; c < nch; c++) expq.push_back(exp_word(c, pol, rj, pdm));
      drain("R5 R6 R7 sample word");
      brd(A_DATA, v);
      chk("R8 empty read value", v, 32'd0);
      brd(A_RAW, v);
      chk("R8 empty status bit", (v >> 3) & 32'd1, 32'd1);
   endtask

   initial begin
      #(200000 * 20);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int t0, t1, t2;
      int ratios[7] = '{8, 5, 10, 8, 16, 5, 5};
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state and readback
      chk("R1 mic_clk reset", 32'(mic_clk), 0);
      chk("R1 dma_req reset", 32'(dma_req), 0);
      chk("R1 irq reset", 32'(irq), 0);
      brd(A_CTRL, v); chk("R1 ctrl reset", v, 0);
      brd(A_FIFO, v); chk("R1 fifo ctrl reset", v, 0);
      bwr(A_CTRL, 32'h3F8);
      brd(A_CTRL, v); chk("R1 ctrl readback", v, 32'h3F8);

      // R2 period per code
      for (int c = 0; c < 7; c++) begin
         bwr(A_CTRL, 32'd1 | (32'(c) << 7));
         wait_rise(t0); wait_rise(t1); wait_rise(t2);
         chk($sformatf("R2 period code %0d", c), 32'(t2 - t1), 32'(ratios[c]));
      end
      // R2 change waits for the period boundary
      bwr(A_CTRL, 32'd1);
      wait_rise(t0); wait_rise(t0);
      repeat (2) @(negedge clk);
      bwr(A_CTRL, 32'd1 | (32'd4 << 7));
      wait_rise(t1); wait_rise(t2);
      chk("R2 running period kept", 32'(t1 - t0), 32'd8);
      chk("R2 new period", 32'(t2 - t1), 32'd16);

      // R3 idle low
      bwr(A_CTRL, 32'd4 << 7);
      hi = 0;
      repeat (40) begin @(negedge clk); if (mic_clk) hi++; end
      chk("R3 idle clock low", 32'(hi), 0);

      // R4 pair 1 off blocks the higher pairs
      bwr(A_CTRL, 32'h400);
      bwr(A_CTRL, 32'h6 | (32'd1 << 7));
      hi = 0;
      repeat (80) begin @(negedge clk); if (mic_clk) hi++; end
      chk("R4 no clock without pair 1", 32'(hi), 0);
      brd(A_FIFO, v); chk("R4 nothing captured", (v >> 16) & 32'hFF, 0);

      // R5 R6 R7 captures
      cap_run(3'b001, 3'b000, 1'b0, 3'b001);
      cap_run(3'b111, 3'b010, 1'b1, 3'b011);
      cap_run(3'b011, 3'b001, 1'b0, 3'b010);
      cap_run(3'b101, 3'b000, 1'b1, 3'b111); // R4 acts as pair 1 only

      // R9 R10 DMA
      bwr(A_CTRL, 32'h400);
      bwr(A_FIFO, 32'd1);
      brd(A_DSET, v); chk("R9 dma enable reset", v, 0);
      bwr(A_DSET, 32'd1);
      brd(A_DCLR, v); chk("R9 dma enable readback", v, 1);
      bwr(A_CTRL, 32'd1 | (32'd1 << 7));
      chk("R10 no request before data", 32'(dma_req), 0);
      repeat (40) @(negedge clk);
      chk("R10 request at threshold", 32'(dma_req), 1);
      brd(A_RAW, v); chk("R11 threshold status", v & 32'd1, 1);
      bwr(A_DCLR, 32'd1);
      chk("R9 clear drops request", 32'(dma_req), 0);
      bwr(A_DSET, 32'd1);
      chk("R9 set restores request", 32'(dma_req), 1);
      bwr(A_CTRL, 32'd1 << 7);
      chk("R10 no request when stopped", 32'(dma_req), 0);
      bwr(A_CTRL, 32'h400);
      bwr(A_FIFO, 32'd15);
      bwr(A_CTRL, 32'd1 | (32'd1 << 7));
      repeat (100) @(negedge clk);
      chk("R10 below 15x2 words", 32'(dma_req), 0);
      repeat (300) @(negedge clk);
      chk("R10 reached 15x2 words", 32'(dma_req), 1);
      bwr(A_CTRL, 32'd1 << 7);

      // R12 soft reset
      bwr(A_CTRL, 32'h400);
      brd(A_FIFO, v); chk("R12 flushed level", v, 32'd15);
      brd(A_CTRL, v); chk("R12 bit self clears", v, 0);
      brd(A_RAW, v); chk("R12 raw cleared", v, 0);

      // R11 interrupts
      bwr(A_IESET, 32'd8);
      brd(A_IECLR, v); chk("R11 enable readback", v, 8);
      chk("R11 irq quiet", 32'(irq), 0);
      brd(A_DATA, v); chk("R8 empty read zero", v, 0);
      chk("R11 irq on empty read", 32'(irq), 1);
      brd(A_STAT, v); chk("R11 masked status", v, 8);
      bwr(A_STAT, 32'd8);
      chk("R11 irq cleared", 32'(irq), 0);
      bwr(A_IECLR, 32'd8);
      brd(A_IESET, v); chk("R11 enable cleared", v, 0);

      // R13 overflow
      bwr(A_CTRL, 32'h400);
      pdm_in = 3'b111;
      bwr(A_CTRL, 32'h7 | (32'd1 << 7));
      repeat (600) @(negedge clk);
      bwr(A_CTRL, 32'd1 << 7);
      repeat (10) @(negedge clk);
      brd(A_FIFO, v); chk("R13 level at depth", (v >> 16) & 32'hFF, 32'(DEPTH));
      brd(A_RAW, v); chk("R13 full status", (v >> 1) & 32'd1, 1);
      expq.push_back(exp_word(0, 3'b000, 1'b0, 3'b111));
      drain("R13 oldest word kept");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule